// File: doc/BRIEF.md
# Serial Audio DAC Word Transmitter

This block feeds an 18-bit two's complement audio sample stream to a serial-input converter over three wires. The wires are a bit clock, a data line and a latch strobe. The bit clock comes from the system clock through a fixed even divider. Each sample occupies a slot of a fixed number of bit clocks, from 18 to 24. The sample sits at the tail end of the slot, most significant bit first. Any leading pad positions carry zeros.

The data line and the latch strobe change only when the bit clock falls. The receiver therefore always samples settled levels on the rising edge. The strobe falls at the falling edge that follows the rising edge on which the last data bit was sampled. That is the moment the converter captures the word. The strobe stays low for two bit periods and then returns high for the rest of the slot.

Samples enter through a valid/ready handshake. Ready is high for exactly one system clock per slot, in the cycle whose clock edge starts the next slot. A sample offered in that cycle is sent in that slot. If no sample is offered, the previous sample is sent again, so the output rate never changes.

Top module: `dac_serial_tx`

## Requirements
- R1: The bit clock has a period of CLK_DIV system clocks. It is high for CLK_DIV/2 system clocks and low for CLK_DIV/2 system clocks (CLK_DIV even, at least 4).
- R2: The data line and the latch strobe change only on the system clock edge where the bit clock falls.
- R3: The final 18 bit positions of each slot carry the sample, most significant bit first, as sampled on bit clock rising edges.
- R4: In a slot longer than 18 bit clocks, every position before the sample bits carries a zero.
- R5: Slot positions are numbered from 0. The latch strobe falls on the bit clock falling edge that starts position 0 of a slot. It is low at positions 0 and 1 and high at every later position. Consecutive falls are exactly SLOT_LEN bit clocks apart.
- R6: Every level of the latch strobe lasts across at least one bit clock rising edge before the strobe changes again.
- R7: Ready is high for exactly one system clock per slot. Consecutive ready pulses are SLOT_LEN*CLK_DIV system clocks apart.
- R8: A sample presented with valid high in the ready cycle is the one sent in the slot that starts at that clock edge. The data input is ignored in every other cycle.
- R9: If valid is low in the ready cycle, the slot resends the most recently sent sample.
- R10: During and right after reset, the bit clock is low, the data line is low, the latch strobe is high and ready is low. The first slot carries the value zero unless a sample is accepted for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is offered |
| in_data | input | DATA_W | Two's complement sample |
| in_ready | output | 1 | One-cycle slot-start pulse; the offered sample is taken |
| dac_bclk | output | 1 | Bit clock to the converter |
| dac_sdata | output | 1 | Serial data, valid at bit clock rising edges |
| dac_le | output | 1 | Latch strobe; its falling edge latches the word |

## Verification
The assertions check the edge discipline on every cycle. They confirm that the bit clock holds each level for more than one system clock (R1). They confirm that data and strobe move only with a falling bit clock (R2). They check that the strobe falls only at slot position 0 (R5), that each strobe level spans a rising edge (R6), and that ready never lasts two cycles (R7). The bench's receiver model is the only place that shows the content of the slots. It reassembles every slot from the rising-edge samples. That is how it shows zero padding, MSB-first placement at the slot tail, the strobe pattern, and the choice between a fresh and a repeated sample. None of these can be seen from a single cycle.

// File: rtl/dst_pkg.sv
package dst_pkg;
    // Number of bit periods the latch strobe stays low after it falls
    localparam int DST_LE_LOW_BITS = 2;

    // One-cycle indications that the bit clock changes at the next edge
    typedef struct packed {
        logic rise;
        logic fall;
    } dst_tick_t;
endpackage

// File: rtl/dst_bclk_gen.sv
module dst_bclk_gen
    import dst_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    output logic      bclk_o,
    output dst_tick_t tick_o
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bclk;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        tick_o.rise = (st_q.cnt == CNT_LAST) && !st_q.bclk;
        tick_o.fall = (st_q.cnt == CNT_LAST) && st_q.bclk;
        if (st_q.cnt == CNT_LAST) begin
            st_d.cnt  = '0;
            st_d.bclk = !st_q.bclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, bclk: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o = st_q.bclk;

    // R1
    bclk_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk_o) |=> $stable(bclk_o));
    // R1
    bclk_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk_o) |=> $stable(bclk_o));
endmodule

// File: rtl/dst_slot_ser.sv
module dst_slot_ser
    import dst_pkg::*;
#(
    parameter int DATA_W   = 18,
    parameter int SLOT_LEN = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dst_tick_t         tick_i,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              sdata_o,
    output logic              le_o
);
    localparam int PAD   = SLOT_LEN - DATA_W;
    localparam int POS_W = $clog2(SLOT_LEN);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_LEN - 1);
    localparam logic [POS_W-1:0] PAD_P    = POS_W'(PAD);
    localparam logic [POS_W-1:0] LE_UP_P  = POS_W'(DST_LE_LOW_BITS);

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] shreg;
        logic              sdata;
        logic              le;
    } ser_st_t;

    ser_st_t           st_d, st_q;
    logic [POS_W-1:0]  pos_nx;
    logic [DATA_W-1:0] word_new;

    always_comb begin
        st_d     = st_q;
        in_ready = tick_i.fall && (st_q.pos == POS_LAST);
        pos_nx   = (st_q.pos == POS_LAST) ? '0 : st_q.pos + 1'b1;
        word_new = in_valid ? in_data : st_q.hold;
        if (tick_i.fall) begin
            st_d.pos = pos_nx;
            st_d.le  = (pos_nx >= LE_UP_P);
            if (pos_nx == '0) begin
                st_d.hold = word_new;
                if (PAD == 0) begin
                    st_d.sdata = word_new[DATA_W-1];
                    st_d.shreg = word_new << 1;
                end else begin
                    st_d.sdata = 1'b0;
                    st_d.shreg = word_new;
                end
            end else if (pos_nx < PAD_P) begin
                st_d.sdata = 1'b0;
            end else begin
                st_d.sdata = st_q.shreg[DATA_W-1];
                st_d.shreg = st_q.shreg << 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pos: POS_LAST, hold: '0, shreg: '0, sdata: 1'b0, le: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata_o = st_q.sdata;
    assign le_o    = st_q.le;

    // R7
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);
    // R5
    le_fall_at_slot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(le_o) |-> (st_q.pos == '0));
    // R2
    sdata_on_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> $past(tick_i.fall));
endmodule

// File: rtl/dac_serial_tx.sv
module dac_serial_tx
    import dst_pkg::*;
#(
    parameter int DATA_W   = 18,
    parameter int SLOT_LEN = 24,
    parameter int CLK_DIV  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              dac_bclk,
    output logic              dac_sdata,
    output logic              dac_le
);
    dst_tick_t tick;

    dst_bclk_gen #(.CLK_DIV(CLK_DIV)) u_bclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_o (dac_bclk),
        .tick_o (tick)
    );

    dst_slot_ser #(.DATA_W(DATA_W), .SLOT_LEN(SLOT_LEN)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .sdata_o  (dac_sdata),
        .le_o     (dac_le)
    );

    // Strobe dwell checker: bit clock rises seen since the last strobe change
    logic       le_prev_q;
    logic [1:0] rises_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            le_prev_q <= 1'b1;
            rises_q   <= '0;
        end else begin
            le_prev_q <= dac_le;
            if (dac_le != le_prev_q) begin
                rises_q <= '0;
            end else if ($rose(dac_bclk) && rises_q != 2'd3) begin
                rises_q <= rises_q + 1'b1;
            end
        end
    end

    // R6
    le_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_le != le_prev_q) |-> (rises_q != 2'd0));
    // R2
    le_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_le) |-> $fell(dac_bclk));
endmodule

// File: tb/dac_serial_tx_bench.sv
module dac_serial_tx_bench;
    localparam int DATA_W   = 18;
    localparam int SLOT_LEN = 24;
    localparam int CLK_DIV  = 4;
    localparam int PAD      = SLOT_LEN - DATA_W;
    localparam int N_SLOTS  = 300;
    localparam int WATCHDOG = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ready, dac_bclk, dac_sdata, dac_le;

    int n_checks = 0;
    int n_fail   = 0;
    int done_slots = 0;

    logic [DATA_W-1:0] exp_word [0:1023];
    bit                exp_rep  [0:1023];
    int wr_i = 0;
    int rd_i = 0;

    always #10 clk = !clk;

    dac_serial_tx #(.DATA_W(DATA_W), .SLOT_LEN(SLOT_LEN), .CLK_DIV(CLK_DIV)) u_dac_serial_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .dac_bclk(dac_bclk), .dac_sdata(dac_sdata), .dac_le(dac_le)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] directed_word(input int k);
        case (k)
            0: return 18'h1FFFF;
            1: return 18'h20000;
            3: return 18'h00000;
            default: return 18'h3FFFF;
        endcase
    endfunction

    function automatic bit le_expected(input int pos);
        return pos >= 2;
    endfunction

    // Receiver model: samples on bit clock rising edges
    bit     rx_active = 0;
    bit     rx_prev_le = 1;
    int     rx_cnt = 0;
    logic   rx_bits [0:SLOT_LEN-1];
    logic   rx_les  [0:SLOT_LEN-1];

    task automatic close_slot();
        logic [DATA_W-1:0] w;
        int pad_ones;
        pad_ones = 0;
        w = '0;
        // R5: strobe falls are SLOT_LEN bit clocks apart
        check(rx_cnt == SLOT_LEN, "R5 slot length", rx_cnt, SLOT_LEN);
        for (int i = 0; i < PAD; i++) if (rx_bits[i] !== 1'b0) pad_ones++;
        // R4
        check(pad_ones == 0, "R4 pad bits zero", pad_ones, 0);
        for (int i = 0; i < SLOT_LEN; i++)
            check(rx_les[i] === le_expected(i), "R5 strobe pattern", rx_les[i], le_expected(i));
        for (int i = 0; i < DATA_W; i++) w = {w[DATA_W-2:0], rx_bits[PAD+i]};
        if (rd_i < wr_i) begin
            if (exp_rep[rd_i])
                check(w === exp_word[rd_i], "R9 resent sample", w, exp_word[rd_i]);
            else
                check(w === exp_word[rd_i], "R3 R8 sample MSB first", w, exp_word[rd_i]);
            rd_i++;
        end else begin
            check(0, "R3 slot without expected sample", w, 0);
        end
        done_slots++;
    endtask

    initial begin
        forever begin
            @(posedge dac_bclk);
            #1;
            if (rst_n) begin
                if (!dac_le && rx_prev_le) begin
                    if (rx_active) close_slot();
                    rx_active = 1;
                    rx_cnt = 0;
                end
                if (rx_active) begin
                    if (rx_cnt < SLOT_LEN) begin
                        rx_bits[rx_cnt] = dac_sdata;
                        rx_les[rx_cnt]  = dac_le;
                    end
                    rx_cnt++;
                end
                rx_prev_le = dac_le;
            end
        end
    end

    // Cycle-level monitor on the falling system clock edge
    int   cyc = 0;
    int   run = 0;
    int   runs_seen = 0;
    logic last_b = 1'b0;
    logic last_s = 1'b0;
    logic last_rdy = 1'b0;
    int   last_rdy_cyc = -1;

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (dac_bclk === last_b) run++;
                else begin
                    // R1
                    if (runs_seen >= 1) check(run == CLK_DIV/2, "R1 bit clock half period", run, CLK_DIV/2);
                    runs_seen++;
                    run = 1;
                end
                // R2
                if (dac_sdata !== last_s)
                    check(last_b === 1'b1 && dac_bclk === 1'b0, "R2 data moves on falling bit clock", dac_bclk, 0);
                if (in_ready) begin
                    // R7
                    check(!last_rdy, "R7 ready one cycle", last_rdy, 0);
                    if (last_rdy_cyc >= 0)
                        check(cyc - last_rdy_cyc == SLOT_LEN*CLK_DIV, "R7 ready spacing",
                              cyc - last_rdy_cyc, SLOT_LEN*CLK_DIV);
                    last_rdy_cyc = cyc;
                end
                last_b = dac_bclk;
                last_s = dac_sdata;
                last_rdy = in_ready;
            end
        end
    end

    // Stimulus
    initial begin
        int  k;
        bit  v;
        logic [DATA_W-1:0] d;
        logic [DATA_W-1:0] last_sent;
        void'($urandom(32'h5EED_0D17));
        k = 0;
        last_sent = '0;
        repeat (4) @(negedge clk);
        // R10: reset state
        check(dac_bclk === 1'b0, "R10 reset bit clock", dac_bclk, 0);
        check(dac_sdata === 1'b0, "R10 reset data", dac_sdata, 0);
        check(dac_le === 1'b1, "R10 reset strobe", dac_le, 1);
        check(in_ready === 1'b0, "R10 reset ready", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_le === 1'b1 && dac_bclk === 1'b0 && in_ready === 1'b0, "R10 after reset",
              {dac_le, dac_bclk, in_ready}, 3'b100);
        while (done_slots < N_SLOTS && cyc < WATCHDOG) begin
            @(negedge clk);
            if (in_ready) begin
                if (k < 5) begin
                    v = (k != 2);
                    d = directed_word(k);
                end else begin
                    v = ($urandom % 10) < 7;
                    d = DATA_W'($urandom);
                end
                in_valid = v;
                in_data  = d;
                if (v) last_sent = d;
                exp_word[wr_i % 1024] = last_sent;
                exp_rep[wr_i % 1024]  = !v;
                wr_i++;
                k++;
            end else begin
                // R8: data offered outside the ready cycle must be ignored
                in_valid = ($urandom % 2) == 1;
                in_data  = DATA_W'($urandom);
            end
        end
        if (cyc >= WATCHDOG) check(0, "watchdog expired", cyc, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule